// File: doc/BRIEF.md
# Receive Address Filter and Buffer Writer

This block sits behind a network receiver and takes its stream of 16-bit words. The first word of each packet carries the destination host in its upper byte. The block uses that byte and the local host address to decide whether the packet is for this station. An accepted packet is copied word by word into a memory buffer through a single write port. The buffer is described by a base address and a length in words, both sampled when the packet is accepted.

The receiver raises an attention flag on the status word that closes each packet. When that word arrives, the block emits a one-cycle completion record. The record carries a status code and an ending count: the number of buffer words left unused, where the trailing CRC word is written to memory but not counted. Error cases also produce a completion record: a zero-length buffer, a buffer overflow, and a packet that holds only its status word. A rejected packet produces no record.

Internally, a write pointer runs upward from minus the buffer length. A one-word holding register delays each data word by one arrival, so the word that precedes the status word is recognised as the CRC.

Top module: `rx_filter_writer`

## Requirements
- R1: The destination is bits [15:8] of the first word of a packet. A packet is accepted when any of these holds: the destination is 0, the destination equals `host_addr`, or `host_addr` is 0.
- R2: For a rejected packet, the block makes no memory write and no completion record. Every word up to and including the next word with `rx_attn` high is discarded. The word after that is treated as the first word of a new packet.
- R3: For an accepted packet, the words before the status word are written in arrival order to `buf_base`, `buf_base+1`, and so on. This includes the CRC word. The write of a word appears one cycle after the clock edge that takes in the following word.
- R4: On a normal end, `done_status` equals the status word ANDed with 16'h00FF and then XORed with 16'h0F00. `done_count` equals `buf_count` minus the number of words written before the CRC.
- R5: If `buf_count` is 0 when a packet is accepted, the block makes no write. `done_status` is 16'h0C00 and `done_count` is 0. The rest of the packet is discarded through its status word.
- R6: When the buffer becomes exactly full and the next word is the status word, the last held word is treated as the CRC and is not written. The status is formed as in R4, and `done_count` is 0.
- R7: When the buffer is full and the next word is not a status word, `done_status` is 16'h0E00 and `done_count` is 0. The rest of the packet is discarded with no further writes and no second record.
- R8: If the first word of a packet already has `rx_attn` high, the block makes no write. `done_status` is formed from that word as in R4, and `done_count` equals `buf_count`.
- R9: `done` is high for exactly one cycle, starting one cycle after the edge that takes in the status word (or the word that causes the error in R5 and R7).
- R10: A synchronous reset clears `done` and `mem_we` and returns the block to waiting for a first word. `rx_on` is low during reset, low in each cycle that `done` is high, and high otherwise. Words offered while `rx_on` is low are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rx_valid | input | 1 | A received word is present this cycle |
| rx_word | input | 16 | Received word |
| rx_attn | input | 1 | The word is the end-of-packet status |
| host_addr | input | 8 | Local host address; 0 accepts every packet |
| buf_base | input | 16 | First buffer address |
| buf_count | input | 16 | Buffer length in words |
| mem_we | output | 1 | Memory write strobe |
| mem_addr | output | 16 | Memory write address |
| mem_wdata | output | 16 | Memory write data |
| done | output | 1 | Completion record valid (one cycle) |
| done_status | output | 16 | Completion status code |
| done_count | output | 16 | Ending word count |
| rx_on | output | 1 | Receiver enabled |

## Verification
A wrong pointer shows at the next write strobe as a wrong address, in the cycle after the next word arrives. It also shows in `done_count` one cycle after the status word. A wrong state shows within one word as a write or a completion record where none belongs: a rejected packet that writes, a full buffer that stores its CRC, or an overflow that posts twice. The holding register is checked by comparing every written data word with the word received one arrival earlier.

// File: rtl/rx_filter_writer.sv
module rx_filter_writer #(
  parameter int W = 16,
  parameter int HW = 8,
  parameter logic [W-1:0] STAT_MASK  = 16'h00FF,
  parameter logic [W-1:0] DONE_CODE  = 16'h0F00,
  parameter logic [W-1:0] CZERO_CODE = 16'h0C00,
  parameter logic [W-1:0] OVFL_CODE  = 16'h0E00
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rx_valid,
  input  logic [W-1:0]  rx_word,
  input  logic          rx_attn,
  input  logic [HW-1:0] host_addr,
  input  logic [W-1:0]  buf_base,
  input  logic [W-1:0]  buf_count,
  output logic          mem_we,
  output logic [W-1:0]  mem_addr,
  output logic [W-1:0]  mem_wdata,
  output logic          done,
  output logic [W-1:0]  done_status,
  output logic [W-1:0]  done_count,
  output logic          rx_on
);

  typedef enum logic [1:0] {S_IDLE, S_SKIP, S_RECV, S_FULL} state_t;

  state_t        st;
  logic [W-1:0]  ptr, held, base_q, len_q;
  logic          take, hit;
  logic [HW-1:0] dst;
  logic [W-1:0]  ptr_inc, fin_stat;

  assign take     = rx_valid & rx_on;
  assign dst      = rx_word[W-1 -: HW];
  assign hit      = (dst == '0) || (dst == host_addr) || (host_addr == '0);
  assign ptr_inc  = ptr + 1'b1;
  assign fin_stat = (rx_word & STAT_MASK) ^ DONE_CODE;

  always_ff @(posedge clk) begin
    if (rst) begin
      st          <= S_IDLE;
      ptr         <= '0;
      held        <= '0;
      base_q      <= '0;
      len_q       <= '0;
      mem_we      <= 1'b0;
      mem_addr    <= '0;
      mem_wdata   <= '0;
      done        <= 1'b0;
      done_status <= '0;
      done_count  <= '0;
      rx_on       <= 1'b0;
    end else begin
      mem_we <= 1'b0;
      done   <= 1'b0;
      rx_on  <= 1'b1;
      if (take) begin
        case (st)
          S_IDLE: begin
            if (rx_attn) begin
              done        <= 1'b1;
              rx_on       <= 1'b0;
              done_status <= fin_stat;
              done_count  <= buf_count;
            end else if (!hit) begin
              st <= S_SKIP;
            end else if (buf_count == '0) begin
              done        <= 1'b1;
              rx_on       <= 1'b0;
              done_status <= CZERO_CODE;
              done_count  <= '0;
              st          <= S_SKIP;
            end else begin
              ptr    <= -buf_count;
              held   <= rx_word;
              base_q <= buf_base;
              len_q  <= buf_count;
              st     <= S_RECV;
            end
          end
          S_SKIP: begin
            if (rx_attn) st <= S_IDLE;
          end
          S_RECV: begin
            mem_we    <= 1'b1;
            mem_addr  <= base_q + len_q + ptr;
            mem_wdata <= held;
            ptr       <= ptr_inc;
            if (rx_attn) begin
              done        <= 1'b1;
              rx_on       <= 1'b0;
              done_status <= fin_stat;
              done_count  <= -ptr;
              st          <= S_IDLE;
            end else begin
              held <= rx_word;
              if (ptr_inc == '0) st <= S_FULL;
            end
          end
          S_FULL: begin
            done       <= 1'b1;
            rx_on      <= 1'b0;
            done_count <= '0;
            if (rx_attn) begin
              done_status <= fin_stat;
              st          <= S_IDLE;
            end else begin
              done_status <= OVFL_CODE;
              st          <= S_SKIP;
            end
          end
          default: st <= S_IDLE;
        endcase
      end
    end
  end

  p_reject_skips_r1: assert property (@(posedge clk) disable iff (rst)
    (take && st == S_IDLE && !rx_attn && !hit) |=> (st == S_SKIP && !done && !mem_we));

  p_skip_silent_r2: assert property (@(posedge clk) disable iff (rst)
    (st == S_SKIP) |=> !mem_we);

  p_write_from_recv_r3: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> $past(st == S_RECV));

  p_ptr_nonzero_r3: assert property (@(posedge clk) disable iff (rst)
    (st == S_RECV) |-> (ptr != '0));

  p_czero_count_r5: assert property (@(posedge clk) disable iff (rst)
    (done && done_status == CZERO_CODE) |-> (done_count == '0 && !mem_we));

  p_full_no_crc_r6: assert property (@(posedge clk) disable iff (rst)
    (st == S_FULL && take) |=> (!mem_we && done && done_count == '0));

  p_done_pulse_r9: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  p_rx_off_at_done_r10: assert property (@(posedge clk) disable iff (rst)
    done |-> !rx_on);

endmodule

// File: tb/rx_filter_writer_tb.sv
module rx_filter_writer_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst;
  logic        rx_valid, rx_attn;
  logic [15:0] rx_word, buf_base, buf_count;
  logic [7:0]  host_addr;
  logic        mem_we, done, rx_on;
  logic [15:0] mem_addr, mem_wdata, done_status, done_count;

  int n_chk = 0;
  int n_fail = 0;

  logic [15:0] wa [0:15];
  logic [15:0] wd [0:15];
  int          nw;
  int          nd;
  logic [15:0] last_stat, last_cnt;

  always #(CLK_PERIOD/2) clk = ~clk;

  rx_filter_writer u_dut (
    .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_word(rx_word), .rx_attn(rx_attn),
    .host_addr(host_addr), .buf_base(buf_base), .buf_count(buf_count),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .done(done), .done_status(done_status), .done_count(done_count), .rx_on(rx_on)
  );

  always begin
    @(posedge clk);
    #(CLK_PERIOD/4);
    if (mem_we && nw < 16) begin
      wa[nw] = mem_addr;
      wd[nw] = mem_wdata;
      nw = nw + 1;
    end
    if (done) begin
      nd = nd + 1;
      last_stat = done_status;
      last_cnt  = done_count;
    end
  end

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic clr;
    nw = 0;
    nd = 0;
  endtask

  task automatic send(input logic [15:0] w, input logic a);
    rx_word = w; rx_attn = a; rx_valid = 1'b1;
    @(negedge clk);
    rx_valid = 1'b0; rx_attn = 1'b0;
  endtask

  task automatic gap(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    rst = 1'b1; rx_valid = 1'b0; rx_attn = 1'b0; rx_word = '0;
    host_addr = 8'h12; buf_base = 16'h1000; buf_count = 16'd8;
    gap(3);
    check(!mem_we && !done, "R10 outputs idle in reset", {mem_we, done}, 0);
    check(!rx_on, "R10 rx_on low in reset", rx_on, 0);
    rst = 1'b0;
    gap(1);
    check(rx_on, "R10 rx_on high after reset", rx_on, 1);
  endtask

  task automatic t_exact;
    clr();
    host_addr = 8'h12; buf_base = 16'h1000; buf_count = 16'd8;
    send(16'h1234, 0); send(16'hA001, 0); send(16'hA002, 0); send(16'hCCCC, 0);
    check(nw == 3, "R3 writes lag one word", nw, 3);
    send(16'h5A5A, 1);
    check(done && !rx_on, "R9 done one cycle after status, R10 rx off", {done, rx_on}, 2);
    gap(1);
    check(!done && rx_on, "R9 done single pulse", {done, rx_on}, 1);
    check(nw == 4, "R3 write count incl CRC", nw, 4);
    check(wa[0] == 16'h1000 && wd[0] == 16'h1234, "R3 first write", {wa[0], wd[0]}, 32'h10001234);
    check(wa[3] == 16'h1003 && wd[3] == 16'hCCCC, "R3 CRC write", {wa[3], wd[3]}, 32'h1003CCCC);
    check(nd == 1 && last_stat == 16'h0F5A, "R4 status mask and xor", last_stat, 16'h0F5A);
    check(last_cnt == 16'd5, "R4 ending count", last_cnt, 5);
  endtask

  task automatic t_broadcast;
    clr();
    host_addr = 8'h12; buf_base = 16'h0200; buf_count = 16'd4;
    send(16'h00AB, 0); send(16'h1111, 0); send(16'h2222, 0); send(16'h00FF, 1);
    gap(2);
    check(nw == 3 && wa[2] == 16'h0202 && wd[1] == 16'h1111, "R1 broadcast accepted", nw, 3);
    check(nd == 1 && last_stat == 16'h0FFF && last_cnt == 16'd2, "R4 broadcast record", {last_stat, last_cnt}, 32'h0FFF0002);
  endtask

  task automatic t_promisc;
    clr();
    host_addr = 8'h00; buf_base = 16'h0300; buf_count = 16'd5;
    send(16'h7701, 0); send(16'h4444, 0); send(16'h0003, 1);
    gap(2);
    check(nw == 2 && wa[1] == 16'h0301 && wd[1] == 16'h4444, "R1 promiscuous accepted", nw, 2);
    check(nd == 1 && last_cnt == 16'd4 && last_stat == 16'h0F03, "R4 promiscuous record", {last_stat, last_cnt}, 32'h0F030004);
  endtask

  task automatic t_reject;
    clr();
    host_addr = 8'h12; buf_base = 16'h0400; buf_count = 16'd6;
    send(16'h3401, 0); send(16'h1200, 0); send(16'h0000, 0); send(16'h0011, 1);
    gap(2);
    check(nw == 0 && nd == 0, "R2 rejected packet silent", {nw[15:0], nd[15:0]}, 0);
    send(16'h12EE, 0); send(16'h5555, 0); send(16'h0001, 1);
    gap(2);
    check(nw == 2 && wd[0] == 16'h12EE && wa[0] == 16'h0400, "R2 next packet accepted after skip", nw, 2);
    check(nd == 1 && last_cnt == 16'd5, "R2 next packet record", last_cnt, 5);
  endtask

  task automatic t_czero;
    clr();
    host_addr = 8'h12; buf_base = 16'h0500; buf_count = 16'd0;
    send(16'h1201, 0);
    check(done && done_status == 16'h0C00 && done_count == 0, "R5 count zero record", done_status, 16'h0C00);
    send(16'h1202, 0); send(16'h3333, 0); send(16'h0001, 1);
    gap(2);
    check(nw == 0 && nd == 1, "R5 no writes, one record", {nw[15:0], nd[15:0]}, 1);
  endtask

  task automatic t_full;
    clr();
    host_addr = 8'h12; buf_base = 16'h0600; buf_count = 16'd3;
    send(16'h12A0, 0); send(16'hB001, 0); send(16'hB002, 0); send(16'hCC00, 0);
    send(16'h0042, 1);
    gap(2);
    check(nw == 3 && wd[2] == 16'hB002 && wa[2] == 16'h0602, "R6 CRC not written", nw, 3);
    check(nd == 1 && last_stat == 16'h0F42 && last_cnt == 0, "R6 full-end record", {last_stat, last_cnt}, 32'h0F420000);
  endtask

  task automatic t_overflow;
    clr();
    host_addr = 8'h12; buf_base = 16'h0700; buf_count = 16'd3;
    send(16'h12A0, 0); send(16'hB001, 0); send(16'hB002, 0); send(16'hB003, 0);
    send(16'hB004, 0);
    check(done && done_status == 16'h0E00 && done_count == 0, "R7 overflow record", done_status, 16'h0E00);
    send(16'hCC00, 0); send(16'h0001, 1);
    gap(2);
    check(nw == 3 && nd == 1, "R7 no extra writes or records", {nw[15:0], nd[15:0]}, 32'h00030001);
  endtask

  task automatic t_empty;
    clr();
    host_addr = 8'h12; buf_base = 16'h0800; buf_count = 16'd6;
    send(16'h1234, 1);
    gap(2);
    check(nw == 0 && nd == 1 && last_stat == 16'h0F34 && last_cnt == 16'd6, "R8 empty packet record", {last_stat, last_cnt}, 32'h0F340006);
  endtask

  task automatic t_rx_off;
    clr();
    host_addr = 8'h12; buf_base = 16'h0900; buf_count = 16'd6;
    send(16'h1234, 1);
    send(16'h5678, 1);
    gap(2);
    check(nd == 1 && last_stat == 16'h0F34, "R10 word ignored while rx_on low", nd, 1);
  endtask

  initial begin
    nw = 0; nd = 0;
    t_reset();
    t_exact();
    t_broadcast();
    t_promisc();
    t_reject();
    t_czero();
    t_full();
    t_overflow();
    t_empty();
    t_rx_off();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule